// File: doc/BRIEF.md
# Lockable Byte-Wide NVRAM with Wide-Access Splitting

This block models a byte-addressed, battery-backed storage array with a small control window at the top of its address range. The host issues 8-, 16- or 32-bit requests. A front end splits each wide request into single-byte operations, one per clock cycle. The most significant byte goes to the lowest address. Every byte is checked for range and protection on its own. Two lock bits guard two 16-byte regions low in the array. While a guard is set, reads of the region return 0xFF and writes to it are dropped. Reads beyond the populated size also return 0xFF.

The control window is the highest 16 bytes of the populated size, starting at `MEM_BYTES-16`. It holds a flags byte, alarm fields, the lock register and a year register. The year register feeds the time counters, which sit outside this block, through the `year_since_1900` output. The parameter `SIMPLE` selects a reduced chip variant. In that variant, window offsets 0 to 7 are ordinary storage, and the year register counts from 1968 instead of 1900.

Top module: `nvram_wide_access`

## Requirements
- R1: When lock bit 0 is set, byte addresses 0x20 to 0x2F read as 0xFF and ignore writes. When the bit is clear they behave as storage.
- R2: When lock bit 1 is set, byte addresses 0x30 to 0x3F read as 0xFF and ignore writes.
- R3: A byte address at or above `MEM_BYTES` reads as 0xFF, and a write to it changes nothing.
- R4: The lock register sits at window offset 14, which is address `MEM_BYTES-2`. Bit 0 guards the 0x20 region and bit 1 guards the 0x30 region. A write stores data bits 1:0. A read returns the two bits zero-extended. Reset clears both bits.
- R5: In the full variant, the flags byte at window offset 0 always reads 0x00 and ignores writes.
- R6: In the full variant, each alarm field accepts only a valid BCD value, with the low nibble at most 9. Offsets 2 and 3 (seconds and minutes) use data bits 6:0, and the value must be at most 59. Offset 4 (hours) uses bits 5:0, and the value must be at most 23. Offset 5 (date) uses bits 4:0, and the value must be nonzero. A rejected write leaves the stored byte unchanged.
- R7: In the simple variant, window offsets 0 to 7 read and write as ordinary storage.
- R8: The year register sits at offset 15, which is address `MEM_BYTES-1`. A write is taken only when both BCD digits are at most 9. The full variant sets `year_since_1900` to the value written. The simple variant sets it to that value plus 68. A read returns BCD of `year_since_1900` minus the variant's base, which is 0 or 68. After reset the output holds the base.
- R9: `req_size` selects the access width: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. A 16-bit write puts data bits 15:8 at the base address and bits 7:0 at base+1. A 16-bit read returns the byte at the base address in `rdata[15:8]`.
- R10: A 32-bit access touches base to base+3, most significant byte first, with the address wrapping modulo 2^`AW`. Each byte gets its own lock and range check, so an access that straddles a locked region changes only its unguarded bytes.
- R11: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. An N-byte access handles one byte on each of N consecutive edges, starting with that edge. `req_ready` stays low between those edges. `done` pulses for one cycle after the last edge, with read data right-aligned in `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_addr | input | AW | Byte address of the most significant byte |
| req_wdata | input | 32 | Write data, right-aligned |
| req_ready | output | 1 | Block can take a request this cycle |
| done | output | 1 | Access finished in the previous cycle |
| rdata | output | 32 | Read result, right-aligned |
| year_since_1900 | output | 8 | Binary year handed to the time counters |

## Verification
Two things can happen in the same cycle: the last byte of one access raises `done`, and the next request is taken while `req_ready` has gone high again. The bench provokes this by driving the next request at the very sampling point where it sees `done`. Each access's cycle count and result are then judged against a per-byte reference model. The second overlap is a single 32-bit access that crosses a lock boundary, so that guarded and unguarded bytes are handled on successive edges. The bench checks that only the unguarded bytes land. Both variants get identical stimulus side by side.

// File: rtl/nvram_wide_access.sv
module nvram_wide_access #(
  parameter int AW        = 12,
  parameter int MEM_BYTES = 1024,
  parameter bit SIMPLE    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [31:0]   rdata,
  output logic [7:0]    year_since_1900
);

  localparam int MW = $clog2(MEM_BYTES);
  localparam logic [AW:0] SIZE_L = (AW+1)'(MEM_BYTES);
  localparam logic [AW:0] WIN_L  = (AW+1)'(MEM_BYTES - 16);
  localparam logic [AW-1:0] LK0_LO = AW'(32);
  localparam logic [AW-1:0] LK0_HI = AW'(47);
  localparam logic [AW-1:0] LK1_LO = AW'(48);
  localparam logic [AW-1:0] LK1_HI = AW'(63);
  localparam logic [7:0] YBASE = SIMPLE ? 8'd68 : 8'd0;

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] o;
    t = v / 8'd10;
    o = v % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  logic [7:0]    mem [MEM_BYTES];
  logic          active;
  logic [1:0]    rem_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wsh_q;
  logic          wr_q;
  logic [1:0]    lock_q;
  logic [7:0]    year_q;

  assign req_ready       = ~active;
  assign year_since_1900 = year_q;

  logic          fire;
  logic [1:0]    req_last;
  logic [31:0]   req_al;
  logic [AW-1:0] cur_addr;
  logic [31:0]   cur_wsh;
  logic          cur_wr;
  logic [1:0]    cur_rem;
  logic [7:0]    cur_d;

  assign fire     = active | req_valid;
  assign req_last = (req_size == 2'd0) ? 2'd0 : (req_size == 2'd1) ? 2'd1 : 2'd3;
  assign req_al   = (req_size == 2'd0) ? {req_wdata[7:0], 24'h0} :
                    (req_size == 2'd1) ? {req_wdata[15:0], 16'h0} : req_wdata;
  assign cur_addr = active ? addr_q : req_addr;
  assign cur_wsh  = active ? wsh_q  : req_al;
  assign cur_wr   = active ? wr_q   : req_write;
  assign cur_rem  = active ? rem_q  : req_last;
  assign cur_d    = cur_wsh[31:24];

  logic          in_range;
  logic          locked;
  logic          win;
  logic [3:0]    off;
  logic [MW-1:0] midx;
  logic          alarm_ok;
  logic          year_ok;
  logic          flags_ro;

  assign in_range = {1'b0, cur_addr} < SIZE_L;
  assign locked   = (lock_q[0] && cur_addr >= LK0_LO && cur_addr <= LK0_HI) ||
                    (lock_q[1] && cur_addr >= LK1_LO && cur_addr <= LK1_HI);
  assign win      = in_range && ({1'b0, cur_addr} >= WIN_L);
  assign off      = cur_addr[3:0];
  assign midx     = cur_addr[MW-1:0];
  assign year_ok  = (cur_d[7:4] <= 4'd9) && (cur_d[3:0] <= 4'd9);
  assign flags_ro = !SIMPLE && win && off == 4'd0;

  always_comb begin
    logic [7:0] m;
    alarm_ok = 1'b1;
    m = 8'h00;
    if (!SIMPLE && win) begin
      case (off)
        4'd2, 4'd3: begin
          m = cur_d & 8'h7F;
          alarm_ok = (m[3:0] <= 4'd9) && (bcd2bin(m) <= 8'd59);
        end
        4'd4: begin
          m = cur_d & 8'h3F;
          alarm_ok = (m[3:0] <= 4'd9) && (bcd2bin(m) <= 8'd23);
        end
        4'd5: begin
          m = cur_d & 8'h1F;
          alarm_ok = (m[3:0] <= 4'd9) && (m != 8'h00);
        end
        default: alarm_ok = 1'b1;
      endcase
    end
  end

  logic reg_slot;
  logic plain_wr;
  logic lock_wr;
  logic year_wr;

  assign reg_slot = win && (off == 4'd14 || off == 4'd15);
  assign plain_wr = fire && cur_wr && in_range && !locked && !reg_slot && !flags_ro && alarm_ok;
  assign lock_wr  = fire && cur_wr && win && off == 4'd14;
  assign year_wr  = fire && cur_wr && win && off == 4'd15 && year_ok;

  logic [7:0] rd_byte;
  always_comb begin
    if (!in_range || locked)     rd_byte = 8'hFF;
    else if (win && off == 4'd15) rd_byte = bin2bcd(year_q - YBASE);
    else if (win && off == 4'd14) rd_byte = {6'd0, lock_q};
    else if (flags_ro)            rd_byte = 8'h00;
    else                          rd_byte = mem[midx];
  end

  always_ff @(posedge clk) begin
    if (plain_wr) mem[midx] <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem_q  <= 2'd0;
      addr_q <= '0;
      wsh_q  <= 32'h0;
      wr_q   <= 1'b0;
      done   <= 1'b0;
      rdata  <= 32'h0;
      lock_q <= 2'b00;
      year_q <= YBASE;
    end else begin
      done <= fire && cur_rem == 2'd0;
      if (fire) begin
        rdata  <= {(active ? rdata[23:0] : 24'h0), rd_byte};
        active <= cur_rem != 2'd0;
        rem_q  <= cur_rem - 2'd1;
        addr_q <= cur_addr + AW'(1);
        wsh_q  <= cur_wsh << 8;
        wr_q   <= cur_wr;
      end
      if (lock_wr) lock_q <= cur_d[1:0];
      if (year_wr) year_q <= bcd2bin(cur_d) + YBASE;
    end
  end

  // R1
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cur_wr && locked) |=> rdata[7:0] == 8'hFF);

  // R3
  oor_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cur_wr && !in_range) |=> rdata[7:0] == 8'hFF);

  // R8
  year_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && cur_wr && win && off == 4'd15) |=> $stable(year_since_1900));

  // R8
  year_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (year_since_1900 >= YBASE) && (year_since_1900 <= YBASE + 8'd99));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cur_rem != 2'd0) |=> !req_ready);

  // R11
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fire && cur_rem == 2'd0));

  // R10
  remain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> rem_q != 2'd3);

endmodule

// File: tb/test_nvram_wide_access.sv
module test_nvram_wide_access;
  localparam int AW  = 12;
  localparam int MEM = 1024;
  localparam int ASPACE = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size  = 2'd0;
  logic [AW-1:0] req_addr  = '0;
  logic [31:0]   req_wdata = 32'h0;
  logic          rdy0, rdy1, dn0, dn1;
  logic [31:0]   rd0, rd1;
  logic [7:0]    yr0, yr1;

  nvram_wide_access #(.AW(AW), .MEM_BYTES(MEM), .SIMPLE(1'b0)) i_nvram_wide_access (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(rdy0), .done(dn0), .rdata(rd0), .year_since_1900(yr0));

  nvram_wide_access #(.AW(AW), .MEM_BYTES(MEM), .SIMPLE(1'b1)) i_nvram_wide_access_lite (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(rdy1), .done(dn1), .rdata(rd1), .year_since_1900(yr1));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] mm0 [MEM];
  logic [7:0] mm1 [MEM];
  logic [1:0] mlock [2];
  logic [7:0] myear [2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tobcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int frombcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bit is_locked(input int v, input int a);
    return (mlock[v][0] && a >= 32 && a <= 47) || (mlock[v][1] && a >= 48 && a <= 63);
  endfunction

  function automatic logic [7:0] mread(input int v, input int a);
    int o;
    if (a >= MEM || is_locked(v, a)) return 8'hFF;
    o = a - (MEM - 16);
    if (o == 15) return tobcd(int'(myear[v]) - (v ? 68 : 0));
    if (o == 14) return {6'd0, mlock[v]};
    if (v == 0 && o == 0) return 8'h00;
    return (v == 0) ? mm0[a] : mm1[a];
  endfunction

  task automatic mwrite(input int v, input int a, input logic [7:0] d);
    int o;
    logic [7:0] m;
    bit ok;
    if (a >= MEM || is_locked(v, a)) return;
    o = a - (MEM - 16);
    if (o == 15) begin
      if (d[7:4] <= 9 && d[3:0] <= 9) myear[v] = 8'(frombcd(d) + (v ? 68 : 0));
      return;
    end
    if (o == 14) begin
      mlock[v] = d[1:0];
      return;
    end
    ok = 1'b1;
    if (v == 0) begin
      if (o == 0) ok = 1'b0;
      if (o == 2 || o == 3) begin m = d & 8'h7F; ok = m[3:0] <= 9 && frombcd(m) <= 59; end
      if (o == 4) begin m = d & 8'h3F; ok = m[3:0] <= 9 && frombcd(m) <= 23; end
      if (o == 5) begin m = d & 8'h1F; ok = m[3:0] <= 9 && m != 0; end
    end
    if (ok) begin
      if (v == 0) mm0[a] = d; else mm1[a] = d;
    end
  endtask

  // Drive at a negedge; returns at the negedge where done is seen.
  task automatic acc(input bit wr, input int sz, input int a, input logic [31:0] wd, input string tag);
    int n, cyc;
    bit ready_bad;
    logic [31:0] e0, e1, msk;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    msk = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
    e0 = 32'h0;
    e1 = 32'h0;
    for (int i = 0; i < n; i++) begin
      int ba;
      logic [7:0] bd;
      ba = (a + i) % ASPACE;
      bd = 8'(wd >> (8 * (n - 1 - i)));
      if (wr) begin
        mwrite(0, ba, bd);
        mwrite(1, ba, bd);
      end else begin
        e0 = (e0 << 8) | {24'h0, mread(0, ba)};
        e1 = (e1 << 8) | {24'h0, mread(1, ba)};
      end
    end
    req_valid = 1'b1;
    req_write = wr;
    req_size  = 2'(sz);
    req_addr  = AW'(a);
    req_wdata = wd;
    @(posedge clk);
    cyc = 0;
    ready_bad = 1'b0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (!dn0 && rdy0) ready_bad = 1'b1;
    end while (!dn0 && cyc < 10);
    // R11: N bytes take N edges, ready low in between
    chk(cyc == n && !ready_bad && dn1, {tag, " R11 cycles"}, 32'(cyc), 32'(n));
    if (!wr) begin
      chk((rd0 & msk) == e0, {tag, " read full"}, rd0 & msk, e0);
      chk((rd1 & msk) == e1, {tag, " read simple"}, rd1 & msk, e1);
    end
    // R8: year output follows model
    chk(yr0 == myear[0] && yr1 == myear[1], {tag, " R8 year"}, {yr0, yr1}, {myear[0], myear[1]});
  endtask

  int win;

  initial begin
    win = MEM - 16;
    void'($urandom(32'd7151));
    mlock[0] = 2'b00; mlock[1] = 2'b00;
    myear[0] = 8'd0;  myear[1] = 8'd68;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy0 && rdy1 && !dn0 && !dn1, "reset R11 idle", {rdy0, rdy1, dn0, dn1}, 4'b1100);
    chk(yr0 == 8'd0 && yr1 == 8'd68, "reset R8 year base", {yr0, yr1}, {8'd0, 8'd68});
    acc(1'b0, 0, win + 14, 32'h0, "reset R4 lock clear");

    for (int a = 0; a < MEM; a += 4) acc(1'b1, 2, a, 32'h0101_0101, "fill");
    acc(1'b1, 0, win + 14, 32'h00, "R4 unlock");
    acc(1'b0, 0, win + 14, 32'h0, "R4 lock readback");

    // R1
    acc(1'b1, 2, 32'h20, 32'hAABB_CCDD, "R1 prime");
    acc(1'b1, 0, win + 14, 32'h01, "R1 set lock0");
    acc(1'b0, 2, 32'h20, 32'h0, "R1 locked read");
    acc(1'b1, 2, 32'h20, 32'h1122_3344, "R1 locked write");
    acc(1'b0, 2, 32'h30, 32'h0, "R1 other window open");
    acc(1'b1, 0, win + 14, 32'h00, "R1 clear");
    acc(1'b0, 2, 32'h20, 32'h0, "R1 old data kept");
    // R2
    acc(1'b1, 2, 32'h3C, 32'h5566_7788, "R2 prime");
    acc(1'b1, 0, win + 14, 32'h02, "R2 set lock1");
    acc(1'b0, 2, 32'h3C, 32'h0, "R2 locked read");
    acc(1'b1, 1, 32'h3E, 32'h0000_9999, "R2 locked write");
    acc(1'b0, 0, win + 14, 32'h0, "R2 R4 lock readback");
    acc(1'b1, 0, win + 14, 32'h00, "R2 clear");
    acc(1'b0, 2, 32'h3C, 32'h0, "R2 old data kept");
    // R10 straddle
    acc(1'b1, 0, win + 14, 32'h01, "R10 set lock0");
    acc(1'b1, 2, 32'h2E, 32'hDEAD_BEEF, "R10 straddle write");
    acc(1'b0, 2, 32'h2E, 32'h0, "R10 straddle read");
    acc(1'b1, 0, win + 14, 32'h00, "R10 clear");
    acc(1'b0, 2, 32'h2E, 32'h0, "R10 straddle after");
    // R3
    acc(1'b1, 2, 32'h500, 32'h1234_5678, "R3 oor write");
    acc(1'b0, 2, 32'h500, 32'h0, "R3 oor read");
    acc(1'b1, 2, MEM - 18, 32'hCAFE_F00D, "R3 R5 edge write");
    acc(1'b0, 2, MEM - 2, 32'h0, "R3 R10 top straddle");
    acc(1'b1, 2, ASPACE - 2, 32'h0A0B_0C0D, "R10 wrap write");
    acc(1'b0, 2, ASPACE - 2, 32'h0, "R10 wrap read");
    // R5 / R7
    acc(1'b1, 0, win, 32'h5A, "R5 R7 flags write");
    acc(1'b0, 0, win, 32'h0, "R5 R7 flags read");
    // R6
    acc(1'b1, 0, win + 2, 32'h59, "R6 sec ok");
    acc(1'b1, 0, win + 3, 32'h60, "R6 min bad");
    acc(1'b1, 0, win + 3, 32'h5A, "R6 min nibble bad");
    acc(1'b1, 0, win + 4, 32'h23, "R6 hour ok");
    acc(1'b1, 0, win + 4, 32'h24, "R6 hour bad");
    acc(1'b1, 0, win + 5, 32'hE0, "R6 date zero");
    acc(1'b1, 0, win + 5, 32'h31, "R6 date masked");
    acc(1'b0, 2, win + 2, 32'h0, "R6 R7 alarm read");
    // R8
    acc(1'b1, 0, win + 15, 32'h99, "R8 year 99");
    acc(1'b0, 0, win + 15, 32'h0, "R8 year read");
    acc(1'b1, 0, win + 15, 32'h9A, "R8 year bad");
    acc(1'b1, 0, win + 15, 32'h00, "R8 year 00");
    acc(1'b0, 0, win + 15, 32'h0, "R8 year read 00");
    // R9
    acc(1'b1, 1, 32'h100, 32'hFFFF_BEAD, "R9 half write");
    acc(1'b0, 0, 32'h100, 32'h0, "R9 high byte");
    acc(1'b0, 0, 32'h101, 32'h0, "R9 low byte");
    acc(1'b0, 1, 32'h100, 32'h0, "R9 half read");
    acc(1'b1, 3, 32'h104, 32'h0102_0304, "R9 size3 word");
    acc(1'b0, 2, 32'h104, 32'h0, "R9 size3 read");

    for (int k = 0; k < 400; k++) begin
      int sel, a, sz;
      sel = int'($urandom % 5);
      case (sel)
        0: a = 24 + int'($urandom % 48);
        1: a = win - 2 + int'($urandom % 18);
        2: a = MEM - 4 + int'($urandom % 8);
        3: a = ASPACE - 4 + int'($urandom % 4);
        default: a = int'($urandom % MEM);
      endcase
      a = a % ASPACE;
      sz = int'($urandom % 4);
      acc(1'(($urandom % 2)), sz, a, $urandom, "R10 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule